// File: doc/BRIEF.md
# Destination Address Recognition Filter

This block decides, for every destination address that a receive path presents, whether the frame should be kept. It holds a small table of 48-bit Ethernet addresses. Each entry has its own enable bit. A control register chooses which classes of frame pass without a table hit: broadcast, multicast (group) and any unicast (station). The same register also turns table comparison on or off. Frame parsing, CRC and DMA stay outside the block.

Software reaches the table through a byte-offset pointer and a 32-bit data window. The table is a byte stream in which each entry takes six consecutive bytes. Entry k therefore begins at stream byte 6k, and most entries straddle a word boundary. The receive path pulses a valid strobe together with the 48-bit destination. Two cycles later the block returns a registered verdict: accept, a match flag and the index of the matching entry.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset the control register and the enable mask read as zero, and every presented destination is rejected with the match flag clear.
- R2: Select code 0 accesses the byte-offset pointer and reads back the value written. Select code 1 reads and writes the 32-bit table word at index pointer/4. Select code 2 accesses the enable mask and select code 3 the control register.
- R3: When the pointer is 128 or more, the data window reads as zero, and a write through it changes no table word.
- R4: Table stream byte b lives in word b/4. Within that word, lane b%4 sits at bits (31-8*(b%4)) down to (24-8*(b%4)). Byte j of entry k is stream byte 6k+j, and byte 0 is the first transmitted byte (destination bits 47:40).
- R5: An entry takes part in matching only when its bit k in the enable mask is set and control bit 0 (compare enable) is set.
- R6: A destination of all ones is broadcast and is accepted when control bit 1 is set. A destination with bit 40 set is group, and any group frame is accepted when control bit 2 is set.
- R7: A non-group destination is accepted without a table hit when control bit 3 is set. A group frame that is not broadcast, seen with bit 2 clear, is accepted only on a table hit.
- R8: The verdict output is valid for exactly one cycle, two cycles after the cycle in which the strobe is sampled.
- R9: When several enabled entries match, the reported index is the lowest one. With no match, both the match flag and the index are zero.
- R10: A table hit accepts the frame whatever bits 1 to 3 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 enable, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first transmitted byte in bits 47:40 |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame accepted |
| dec_match | output | 1 | An enabled entry matched |
| dec_index | output | 5 | Lowest matching entry index |

## Verification
Two situations are hardest to reach from the ports. The first is an entry that straddles a word boundary: its bytes reach the table only through two separate data-window writes, so a lane or byte-order mistake stays hidden unless entries at odd positions are loaded and matched. The stimulus writes whole words and places addresses at entries 1, 2, 4 and 20. Entry 20 occupies the last two words of the table. The second is the choice among several matching entries, which appears only when the same address is loaded twice. The bench loads one address at entries 2 and 20 and shows that entry 2 is reported. It then clears enable bit 2 and shows that entry 20 is reported instead.

// File: rtl/daf_pkg.sv
package daf_pkg;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_EN   = 2'd2,
        SEL_CTL  = 2'd3
    } sel_e;

    // Accept-mode control bits, bit 0 at the bottom
    typedef struct packed {
        logic station;  // bit 3: any unicast
        logic group;    // bit 2: any multicast
        logic bcast;    // bit 1: broadcast
        logic cmp;      // bit 0: table comparison on
    } ctl_t;

    localparam int ADDR_W = 48;
    localparam int BYTES_PER_ENTRY = 6;

endpackage

// File: rtl/daf_table.sv
module daf_table #(
    parameter int N_ENTRIES = 21,
    localparam int NBYTES = N_ENTRIES * 6,
    localparam int NWORDS = (NBYTES + 3) / 4,
    localparam int WIDX_W = $clog2(NWORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WIDX_W-1:0]         wr_idx,
    input  logic [31:0]               wr_data,
    input  logic [WIDX_W-1:0]         rd_idx,
    output logic [31:0]               rd_data,
    output logic [N_ENTRIES-1:0][47:0] entries
);

    logic [NWORDS-1:0][31:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (wr_en) words_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign rd_data = words_q[rd_idx];

    // Unpack the byte stream into entries: stream byte p is in word p/4,
    // lane p%4, lane 0 at the top of the word.
    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
        for (genvar j = 0; j < 6; j++) begin : g_byte
            localparam int P = 6 * k + j;
            assign entries[k][47-8*j -: 8] = words_q[P/4][31-8*(P%4) -: 8];
        end
    end

endmodule

// File: rtl/daf_match.sv
module daf_match #(
    parameter int N_ENTRIES = 21,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0][47:0] entries,
    input  logic [N_ENTRIES-1:0]       enable,
    input  logic                       cmp_en,
    input  logic [47:0]                da,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_idx
);

    logic [N_ENTRIES-1:0] hits;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_cmp
        assign hits[k] = cmp_en && enable[k] && (entries[k] == da);
    end

    // Lowest index wins: scan from the top so the last hit seen is the lowest
    always_comb begin
        hit_idx = '0;
        for (int k = N_ENTRIES - 1; k >= 0; k--) begin
            if (hits[k]) hit_idx = IDX_W'(k);
        end
    end

    assign hit = |hits;

endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
#(
    parameter int N_ENTRIES = 21,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [47:0]      da,
    input  ctl_t             ctl,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_match,
    output logic [IDX_W-1:0] dec_index
);

    typedef struct packed {
        logic             valid;
        logic             accept;
        logic             match;
        logic [IDX_W-1:0] index;
    } dec_t;

    dec_t dec_d, dec_q;
    logic is_bcast, is_group, mode_ok;

    always_comb begin
        is_bcast = &da;
        is_group = da[40];
        if (is_bcast)      mode_ok = ctl.bcast;
        else if (is_group) mode_ok = ctl.group;
        else               mode_ok = ctl.station;

        dec_d = '0;
        if (in_valid) begin
            dec_d.valid  = 1'b1;
            dec_d.match  = hit;
            dec_d.index  = hit ? hit_idx : '0;
            dec_d.accept = hit || mode_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
    assign dec_match  = dec_q.match;
    assign dec_index  = dec_q.index;

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int N_ENTRIES = 21,
    localparam int NBYTES = N_ENTRIES * 6,
    localparam int NWORDS = (NBYTES + 3) / 4,
    localparam int WIDX_W = $clog2(NWORDS),
    localparam int PTR_W = WIDX_W + 3,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             da_valid,
    input  logic [47:0]      da,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_match,
    output logic [IDX_W-1:0] dec_index
);

    typedef struct packed {
        logic [PTR_W-1:0]     ptr;
        ctl_t                 ctl;
        logic [N_ENTRIES-1:0] en;
        logic                 s1_vld;
        logic [47:0]          s1_da;
    } state_t;

    state_t st_d, st_q;

    logic                        in_range;
    logic [WIDX_W-1:0]           widx;
    logic                        tbl_we;
    logic [31:0]                 tbl_rdata;
    logic [N_ENTRIES-1:0][47:0]  entries;
    logic                        hit;
    logic [IDX_W-1:0]            hit_idx;
    sel_e                        sel;

    assign sel      = sel_e'(cfg_sel);
    assign in_range = (st_q.ptr < PTR_W'(NWORDS * 4));
    assign widx     = st_q.ptr[WIDX_W+1:2];
    assign tbl_we   = cfg_we && (sel == SEL_DATA) && in_range;

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = da_valid;
        st_d.s1_da  = da_valid ? da : st_q.s1_da;
        if (cfg_we) begin
            case (sel)
                SEL_PTR: st_d.ptr = cfg_wdata[PTR_W-1:0];
                SEL_EN:  st_d.en  = cfg_wdata[N_ENTRIES-1:0];
                SEL_CTL: st_d.ctl = ctl_t'(cfg_wdata[3:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_PTR:  cfg_rdata = 32'(st_q.ptr);
            SEL_DATA: cfg_rdata = in_range ? tbl_rdata : 32'd0;
            SEL_EN:   cfg_rdata = 32'(st_q.en);
            default:  cfg_rdata = 32'(st_q.ctl);
        endcase
    end

    daf_table #(.N_ENTRIES(N_ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (widx),
        .wr_data (cfg_wdata),
        .rd_idx  (widx),
        .rd_data (tbl_rdata),
        .entries (entries)
    );

    daf_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .entries (entries),
        .enable  (st_q.en),
        .cmp_en  (st_q.ctl.cmp),
        .da      (st_q.s1_da),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    daf_decide #(.N_ENTRIES(N_ENTRIES)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (st_q.s1_vld),
        .da         (st_q.s1_da),
        .ctl        (st_q.ctl),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_match  (dec_match),
        .dec_index  (dec_index)
    );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int N_ENTRIES = 21,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [31:0]      cfg_rdata,
    input logic             da_valid,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_match,
    input logic [IDX_W-1:0] dec_index
);

    AST_VERDICT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |-> ##2 dec_valid); // R8

    AST_NO_SPURIOUS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(da_valid, 2)); // R8

    AST_HIT_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_match |-> dec_accept); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && !dec_match && dec_index == '0)); // R9

    AST_INDEX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_index <= IDX_W'(N_ENTRIES - 1)); // R9

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(cfg_sel)) |-> $stable(cfg_rdata)); // R2

endmodule

bind dest_addr_filter daf_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_rdata  (cfg_rdata),
    .da_valid   (da_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_match  (dec_match),
    .dec_index  (dec_index)
);

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid, dec_accept, dec_match;
    logic [4:0]  dec_index;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] stream [128];

    always #2 clk = ~clk;

    dest_addr_filter u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = data; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    // Place an entry into the bench stream model and write the words it covers
    task automatic load_entry(input int k, input logic [47:0] a);
        for (int j = 0; j < 6; j++) stream[6*k+j] = a[47-8*j -: 8];
        for (int w = (6*k)/4; w <= (6*k+5)/4; w++) begin
            wr(2'd0, 32'(4*w));
            wr(2'd1, {stream[4*w], stream[4*w+1], stream[4*w+2], stream[4*w+3]});
        end
    endtask

    task automatic present(input logic [47:0] a, input bit exp_acc, input bit exp_m,
                           input logic [4:0] exp_idx, input string tag);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        chk(dec_valid == 1'b0, {tag, " early"}, 64'(dec_valid), 64'd0);
        @(negedge clk);
        chk(dec_valid == 1'b1, {tag, " R8 valid"}, 64'(dec_valid), 64'd1);
        chk(dec_accept == exp_acc, {tag, " accept"}, 64'(dec_accept), 64'(exp_acc));
        chk(dec_match == exp_m, {tag, " match"}, 64'(dec_match), 64'(exp_m));
        chk(dec_index == exp_idx, {tag, " index"}, 64'(dec_index), 64'(exp_idx));
        @(negedge clk);
        chk(dec_valid == 1'b0, {tag, " R8 one cycle"}, 64'(dec_valid), 64'd0);
    endtask

    task automatic t_reset();
        rd_chk(2'd3, 32'd0, "R1 control zero");
        rd_chk(2'd2, 32'd0, "R1 enable zero");
        present(48'hFFFF_FFFF_FFFF, 0, 0, 5'd0, "R1 bcast rejected");
        present(48'h0011_2233_4455, 0, 0, 5'd0, "R1 unicast rejected");
    endtask

    task automatic t_regs();
        wr(2'd0, 32'd8);
        rd_chk(2'd0, 32'd8, "R2 pointer readback");
        wr(2'd1, 32'hDEAD_BEEF);
        rd_chk(2'd1, 32'hDEAD_BEEF, "R2 data readback");
        wr(2'd1, 32'd0);
        wr(2'd0, 32'd128);
        wr(2'd1, 32'h1234_5678);
        rd_chk(2'd1, 32'd0, "R3 out of range reads zero");
        wr(2'd0, 32'd124);
        rd_chk(2'd1, 32'd0, "R3 last word untouched");
    endtask

    task automatic t_pack();
        wr(2'd0, 32'd0); wr(2'd1, 32'h0011_2233);
        wr(2'd0, 32'd4); wr(2'd1, 32'h4455_6677);
        wr(2'd0, 32'd8); wr(2'd1, 32'h8899_AABB);
        for (int i = 0; i < 12; i++) stream[i] = 8'(i * 8'h11);
        wr(2'd3, 32'h1);
        wr(2'd2, 32'h0);
        present(48'h0011_2233_4455, 0, 0, 5'd0, "R5 disabled entry ignored");
        wr(2'd2, 32'h3);
        present(48'h0011_2233_4455, 1, 1, 5'd0, "R4 entry0 match");
        present(48'h6677_8899_AABB, 1, 1, 5'd1, "R4 entry1 straddled match");
        wr(2'd3, 32'h0);
        present(48'h6677_8899_AABB, 0, 0, 5'd0, "R5 compare off");
    endtask

    task automatic t_priority();
        load_entry(2, 48'h0200_0000_00AA);
        load_entry(20, 48'h0200_0000_00AA);
        wr(2'd3, 32'h1);
        wr(2'd2, 32'h0010_0004);
        present(48'h0200_0000_00AA, 1, 1, 5'd2, "R9 lowest index");
        wr(2'd2, 32'h0010_0000);
        present(48'h0200_0000_00AA, 1, 1, 5'd20, "R9 last entry");
        present(48'h0200_0000_00AB, 0, 0, 5'd0, "R9 no match zero");
    endtask

    task automatic t_modes();
        wr(2'd3, 32'h3);
        present(48'hFFFF_FFFF_FFFF, 1, 0, 5'd0, "R6 broadcast");
        present(48'h0100_5E00_0001, 0, 0, 5'd0, "R7 group no hit");
        load_entry(4, 48'h0100_5E00_0001);
        wr(2'd2, 32'h10);
        present(48'h0100_5E00_0001, 1, 1, 5'd4, "R7 group hit");
        wr(2'd3, 32'h1);
        present(48'hFFFF_FFFF_FFFF, 0, 0, 5'd0, "R6 broadcast off");
        present(48'h0100_5E00_0001, 1, 1, 5'd4, "R10 hit with modes clear");
        wr(2'd3, 32'h4);
        present(48'h3300_0000_0001, 1, 0, 5'd0, "R6 any group");
        present(48'h0400_0000_0001, 0, 0, 5'd0, "R6 group mode no unicast");
        wr(2'd3, 32'h8);
        present(48'h0400_0000_0001, 1, 0, 5'd0, "R7 any unicast");
        present(48'h3300_0000_0001, 0, 0, 5'd0, "R7 station mode no group");
        rd_chk(2'd3, 32'h8, "R2 control readback");
        wr(2'd3, 32'hF);
        present(48'h0400_0000_0002, 1, 0, 5'd0, "R7 promiscuous unicast");
        present(48'hFFFF_FFFF_FFFF, 1, 0, 5'd0, "R6 promiscuous bcast");
    endtask

    initial begin
        for (int i = 0; i < 128; i++) stream[i] = 8'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_pack();
        t_priority();
        t_modes();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule